// File: doc/BRIEF.md
# Chain and Shift-Register Bias Sequencer

This block is a test pattern for radiation exposure of a programmable device. It places a large number of internal nodes in known logic levels. A free-running 2-bit phase counter advances once per clock pulse. It drives two long chains of non-inverting buffers and a long flip-flop shift register, and the register resets to alternating ones and zeros. One shift of that register by one place, with the inverse of the first stage fed back in, flips every flip-flop in the same cycle.

A tester applies four clock pulses per test sequence. After reset, and after each pulse, it reads the two chain ends and two register taps. Together these four outputs confirm which bias grouping the device is in:

- all nodes nominal;
- chain A inverted;
- chain A and every flip-flop inverted;
- both chains and every flip-flop inverted.

The fourth pulse returns everything to the nominal state, so the sequence can be repeated.

Top module: `bias_pattern`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `chain_a_q`, `chain_b_q`, `tap_lo` and `tap_hi` are all 0. Register stage i holds i mod 2, so the even-position taps read 0.
- R2: After the first pulse from nominal, `chain_a_q` is 1 and `chain_b_q` is 0. Both taps stay 0, because the register does not shift.
- R3: After the second pulse, the register has shifted by one place and every stage has been inverted. Both taps read 1, `chain_a_q` stays 1 and `chain_b_q` stays 0.
- R4: After the third pulse, both chain outputs are 1 and both taps remain 1.
- R5: The fourth pulse shifts the register once more. All four outputs return to 0, and the four-pulse pattern repeats with period 4.
- R6: `tap_lo` and `tap_hi` sit at stages of equal parity, so they are equal at every clock edge outside reset.
- R7: Each chain output is a non-inverting copy, through `CHAIN_LEN` buffer stages, of the level that the phase counter applies at the chain input.
- R8: The register's serial input is the inverse of stage 0. The alternating pattern therefore holds over any number of sequences, including after the whole register length has passed the far tap.
- R9: Asserting `rst_n` at any phase of a sequence returns all outputs to the nominal state of R1. The next pulse then behaves as the first pulse of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test pulse clock; each rising edge is one pulse |
| rst_n | input | 1 | Asynchronous active-low reset to the nominal state |
| chain_a_q | output | 1 | End of buffer chain A |
| chain_b_q | output | 1 | End of buffer chain B |
| tap_lo | output | 1 | Register tap near the serial input |
| tap_hi | output | 1 | Register tap near the far end |

## Verification
Directed runs apply exactly four pulses after reset, and each output set is compared against the expected bias grouping. This separates a misplaced shift (taps changing on the wrong pulse) from a wrong chain drive (chain A and chain B swapped or stuck). Random runs use random pulse bursts and resets placed at random phases. These show whether the phase counter truly restarts from nominal, or whether it carries state across a reset. A long run of several thousand pulses walks the fed-back inverse of stage 0 past the far tap. Only a correct serial input keeps `tap_hi` equal to `tap_lo` there, and that is what separates it from a register that merely resets correctly.

// File: rtl/bias_pattern.sv
module bias_pattern #(
  parameter int CHAIN_LEN = 1000,
  parameter int SR_LEN    = 1536,
  parameter int TAP_LO    = 2,
  parameter int TAP_HI    = SR_LEN - 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic chain_a_q,
  output logic chain_b_q,
  output logic tap_lo,
  output logic tap_hi
);

  logic [1:0]        phase;
  logic              shift_en;
  logic [1:0]        drive;
  logic [SR_LEN-1:0] sr;

  // phases 1 and 3 lead to a flip-flop inversion on the next pulse
  assign shift_en = phase[0];
  assign drive[0] = (phase != 2'd0);
  assign drive[1] = (phase == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 2'd0;
    else        phase <= phase + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SR_LEN; i++) sr[i] <= 1'(i % 2);
    end else if (shift_en) begin
      sr <= {sr[SR_LEN-2:0], ~sr[0]};
    end
  end

  for (genvar c = 0; c < 2; c++) begin : chain
    for (genvar g = 0; g < CHAIN_LEN; g++) begin : stage
      logic n;
      if (g == 0) begin : head
        assign n = drive[c];
      end else begin : body
        assign n = chain[c].stage[g-1].n;
      end
    end
  end

  assign chain_a_q = chain[0].stage[CHAIN_LEN-1].n;
  assign chain_b_q = chain[1].stage[CHAIN_LEN-1].n;
  assign tap_lo    = sr[TAP_LO];
  assign tap_hi    = sr[TAP_HI];

endmodule

module bias_pattern_chk (
  input logic clk,
  input logic rst_n,
  input logic chain_a_q,
  input logic chain_b_q,
  input logic tap_lo,
  input logic tap_hi
);

  assert_taps_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tap_lo == tap_hi);

  assert_b_needs_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chain_b_q |-> chain_a_q);

  assert_taps_need_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tap_lo |-> chain_a_q);

  assert_nominal_then_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_a_q && !tap_lo) |=> (chain_a_q && !chain_b_q && !tap_lo));

  assert_return_nominal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_b_q |=> (!chain_a_q && !chain_b_q && !tap_lo));

  assert_b_rise_taps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_b_q) |-> ($stable(tap_lo) && tap_lo));

  assert_reset_nominal_R1: assert property (@(posedge clk)
    !rst_n |-> (!chain_a_q && !chain_b_q && !tap_lo && !tap_hi));

endmodule

bind bias_pattern bias_pattern_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .chain_a_q(chain_a_q), .chain_b_q(chain_b_q),
  .tap_lo(tap_lo), .tap_hi(tap_hi)
);

// File: tb/test_bias_pattern.sv
module test_bias_pattern;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_a_q, chain_b_q, tap_lo, tap_hi;

  int checks = 0;
  int fails  = 0;
  int exp_phase = 0;

  bias_pattern i_bias_pattern (
    .clk(clk), .rst_n(rst_n),
    .chain_a_q(chain_a_q), .chain_b_q(chain_b_q),
    .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  always #(PERIOD/2) clk = ~clk;

  // expected levels per phase: {chain_a, chain_b, taps}
  function automatic logic [2:0] expect_out(int ph);
    case (ph % 4)
      0: return 3'b000;
      1: return 3'b100;
      2: return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  task automatic check(string req);
    logic [2:0] e;
    logic [3:0] act, exp;
    e   = expect_out(exp_phase);
    act = {chain_a_q, chain_b_q, tap_lo, tap_hi};
    exp = {e, e[0]};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s phase=%0d actual=%b expected=%b", req, exp_phase % 4, act, exp);
    end
  endtask

  function automatic string req_of(int ph);
    case (ph % 4)
      0: return "R5";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic pulse(string req);
    @(posedge clk);
    exp_phase++;
    @(negedge clk);
    check(req);
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst_n = 1'b0;
    exp_phase = 0;
    #1;
    check(req);
    @(negedge clk);
    check(req);
    rst_n = 1'b1;
    #1;
    check(req);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset("R1");
    for (int s = 0; s < 3; s++) begin
      pulse("R2 R7");
      pulse("R3");
      pulse("R4 R7");
      pulse("R5");
    end
    // reset at each phase mid-sequence
    for (int p = 1; p < 4; p++) begin
      for (int k = 0; k < p; k++) pulse(req_of(exp_phase + 1));
      do_reset("R9");
      pulse("R9 R2");
    end
    do_reset("R1");
    // random bursts with occasional resets
    for (int it = 0; it < 200; it++) begin
      int n;
      n = int'($urandom_range(1, 12));
      for (int k = 0; k < n; k++) pulse(req_of(exp_phase + 1));
      if ($urandom_range(0, 7) == 0) do_reset("R9");
    end
    // long run: pattern passes the far tap several times
    do_reset("R1");
    for (int k = 0; k < 4000; k++) begin
      @(posedge clk);
      exp_phase++;
      @(negedge clk);
      if (k % 97 == 0 || k > 3990) check("R8 R6");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule